// File: doc/BRIEF.md
# Interrupt Aggregator with Pin Driver

The block merges three event sources (watchdog expiry, power-fail detection and alarm match) onto a single interrupt pin. Each source owns a sticky flag that records every event it receives, and an enable bit that decides whether that source may assert the pin. A host reads the flags to learn the cause. The flags clear once that read cycle has finished, and only when the write-enable was high at its end.

A control register selects the pin style. The pin can be active high with push-pull drive or active low with open-drain drive. It can also be a level held until the flags are read, or a one-shot pulse of a fixed length in clock ticks, intended to reset a host. In backup mode the alarm is the only source that may assert the pin, and only open-drain active-low signalling is used. Push-pull drive needs the main supply to be good.

The pin is controlled by a three-state machine:
- `PIN_IDLE` means not asserted.
- `PIN_LEVEL` means asserted while a qualified flag is pending.
- `PIN_PULSE` means asserted for a counted window.

Its transitions are:
- idle→level: level mode, and a qualified flag is pending after the edge.
- idle→pulse: pulse mode, and a fresh qualified event arrives.
- level→idle: the qualified flags clear, or the mode changes to pulse.
- pulse→idle: the tick counter expires.

Top module: `irq_combiner`

## Requirements
- R1: After reset the control register reads 00h and the pin is released (`irq_oe_o`=0, `irq_pin_o`=0). Control bits 7:5 always read 0. Control bit map: bit0 watchdog enable, bit1 power-fail enable, bit2 alarm enable, bit3 active-high select, bit4 pulse-mode select.
- R2: An event input that is high at a clock edge sets its flag after that edge, whatever the enable. Flag bit map: bit0 watchdog, bit1 power-fail, bit2 alarm.
- R3: All flags clear at the first edge at which `flag_rd_i` is sampled low after being high, provided `rd_we_hi_i` is high at that edge. Flags do not clear while `flag_rd_i` stays high, or if `rd_we_hi_i` is low when the read ends.
- R4: An event arriving at the same edge that clears the flags leaves its own flag set.
- R5: In level mode the pin is asserted from the edge after which a qualified flag is set, until the edge at which no qualified flag remains.
- R6: A source whose enable bit is 0 never asserts the pin.
- R7: In pulse mode a qualified event starts an assertion lasting exactly `PULSE_TICKS` clock cycles, beginning at the edge that captures the event.
- R8: A qualified event during a running pulse does not lengthen it, but its flag is still set.
- R9: With active-high selected outside backup mode, the pin is driven push-pull (`irq_oe_o`=1) and `irq_pin_o` equals the asserted state while `vcc_ok_i` is 1. While `vcc_ok_i` is 0 the pin is released.
- R10: With active-low selected, `irq_pin_o` is 0 and `irq_oe_o` equals the asserted state (open drain).
- R11: In backup mode only the alarm source can assert the pin, and drive is open-drain active-low regardless of bit3.
- R12: In pulse mode, a flag that is still pending after a pulse ends does not start another pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wdt_evt_i | input | 1 | Watchdog expiry event |
| pwr_evt_i | input | 1 | Power-fail event |
| alm_evt_i | input | 1 | Alarm match event |
| ctrl_wr_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | CTRL_W | Control register write data |
| ctrl_o | output | CTRL_W | Control register contents |
| flag_rd_i | input | 1 | High while a flags read cycle is in progress |
| rd_we_hi_i | input | 1 | Write-enable high at the end of the read cycle |
| flags_o | output | 3 | Sticky source flags |
| backup_i | input | 1 | Backup supply mode |
| vcc_ok_i | input | 1 | Main supply good |
| irq_pin_o | output | 1 | Pin output level |
| irq_oe_o | output | 1 | Pin output enable |

## Verification
The hardest situations to reach from the ports are events that line up exactly with internal edges. One is an event landing on the same edge at which a finished read clears the flags. The other is an event arriving in the middle of a running pulse. The stimulus reaches both with single-cycle event strobes placed relative to a cycle count. It holds the read strobe, drops it together with an alarm strobe, and counts asserted cycles while injecting a second source partway through the pulse. It then waits past the end of the pulse with the flag still pending, to show that no retrigger occurs.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int unsigned NSRC    = 3;
    localparam int unsigned SRC_WDT = 0;
    localparam int unsigned SRC_PWR = 1;
    localparam int unsigned SRC_ALM = 2;

    typedef enum logic [1:0] {
        PIN_IDLE  = 2'd0,
        PIN_LEVEL = 2'd1,
        PIN_PULSE = 2'd2
    } pin_state_e;

    typedef struct packed {
        logic            pulse_mode;
        logic            act_high;
        logic [NSRC-1:0] en;
    } ctrl_t;

    localparam int unsigned CTRL_USED_W = $bits(ctrl_t);

endpackage

// File: rtl/irqc_ctrl_reg.sv
module irqc_ctrl_reg
    import irqc_pkg::*;
#(
    parameter int unsigned CTRL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [CTRL_W-1:0] wdata_i,
    output ctrl_t             ctrl_o,
    output logic [CTRL_W-1:0] rdata_o
);

    localparam int unsigned PAD_W = CTRL_W - CTRL_USED_W;

    ctrl_t ctrl_q;
    logic  unused_hi;

    // Bits above the used field are dropped on write.
    assign unused_hi = ^wdata_i[CTRL_W-1:CTRL_USED_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_i) begin
            ctrl_q <= ctrl_t'(wdata_i[CTRL_USED_W-1:0]);
        end
    end

    assign ctrl_o  = ctrl_q;
    assign rdata_o = {{PAD_W{1'b0}}, ctrl_q};

endmodule

// File: rtl/irqc_flags.sv
module irqc_flags
    import irqc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt_i,
    input  logic            rd_active_i,
    input  logic            rd_we_hi_i,
    output logic [NSRC-1:0] flags_q_o,
    output logic [NSRC-1:0] flags_d_o
);

    logic            rd_prev_q;
    logic            rd_done;
    logic [NSRC-1:0] flag_q;
    logic [NSRC-1:0] flag_d;

    // A read cycle is complete once the strobe drops with write-enable high.
    assign rd_done = rd_prev_q && !rd_active_i && rd_we_hi_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_prev_q <= 1'b0;
        end else begin
            rd_prev_q <= rd_active_i;
        end
    end

    for (genvar s = 0; s < NSRC; s++) begin : g_flag
        // A new event takes priority over the clear.
        assign flag_d[s] = evt_i[s] | (flag_q[s] & ~rd_done);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag_q[s] <= 1'b0;
            end else begin
                flag_q[s] <= flag_d[s];
            end
        end
    end

    assign flags_q_o = flag_q;
    assign flags_d_o = flag_d;

endmodule

// File: rtl/irqc_pin_fsm.sv
module irqc_pin_fsm
    import irqc_pkg::*;
#(
    parameter int unsigned PULSE_TICKS = 6554
) (
    input  logic            clk,
    input  logic            rst_n,
    input  ctrl_t           ctrl_i,
    input  logic [NSRC-1:0] evt_i,
    input  logic [NSRC-1:0] flags_d_i,
    input  logic            backup_i,
    output logic            asserted_o
);

    localparam int unsigned CNT_W = $clog2(PULSE_TICKS + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_TICKS);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

    pin_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [NSRC-1:0] src_mask;
    logic            qual_evt;
    logic            pend_nxt;

    // In backup mode only the alarm may reach the pin.
    always_comb begin
        src_mask = ctrl_i.en;
        if (backup_i) begin
            src_mask = ctrl_i.en & NSRC'(1 << SRC_ALM);
        end
    end

    assign qual_evt = |(evt_i & src_mask);
    assign pend_nxt = |(flags_d_i & src_mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PIN_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            PIN_IDLE: begin
                if (ctrl_i.pulse_mode) begin
                    if (qual_evt) begin
                        state_d = PIN_PULSE;
                        cnt_d   = CNT_LOAD;
                    end
                end else if (pend_nxt) begin
                    state_d = PIN_LEVEL;
                end
            end
            PIN_LEVEL: begin
                if (ctrl_i.pulse_mode || !pend_nxt) begin
                    state_d = PIN_IDLE;
                end
            end
            PIN_PULSE: begin
                if (cnt_q <= CNT_LAST) begin
                    state_d = PIN_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q - CNT_LAST;
                end
            end
            default: begin
                state_d = PIN_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        asserted_o = (state_q != PIN_IDLE);
    end

endmodule

// File: rtl/irqc_pin_drv.sv
module irqc_pin_drv (
    input  logic asserted_i,
    input  logic act_high_i,
    input  logic backup_i,
    input  logic vcc_ok_i,
    output logic pin_o,
    output logic oe_o
);

    always_comb begin
        if (act_high_i && !backup_i) begin
            // Push-pull, only while the main supply is good.
            oe_o  = vcc_ok_i;
            pin_o = asserted_i & vcc_ok_i;
        end else begin
            // Open drain: pull low when asserted, release otherwise.
            oe_o  = asserted_i;
            pin_o = 1'b0;
        end
    end

endmodule

// File: rtl/irq_combiner.sv
module irq_combiner
    import irqc_pkg::*;
#(
    parameter int unsigned PULSE_TICKS = 6554,
    parameter int unsigned CTRL_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wdt_evt_i,
    input  logic              pwr_evt_i,
    input  logic              alm_evt_i,
    input  logic              ctrl_wr_i,
    input  logic [CTRL_W-1:0] ctrl_wdata_i,
    output logic [CTRL_W-1:0] ctrl_o,
    input  logic              flag_rd_i,
    input  logic              rd_we_hi_i,
    output logic [2:0]        flags_o,
    input  logic              backup_i,
    input  logic              vcc_ok_i,
    output logic              irq_pin_o,
    output logic              irq_oe_o
);

    ctrl_t           ctrl;
    logic [NSRC-1:0] evt;
    logic [NSRC-1:0] flags_q;
    logic [NSRC-1:0] flags_d;
    logic            asserted;

    always_comb begin
        evt          = '0;
        evt[SRC_WDT] = wdt_evt_i;
        evt[SRC_PWR] = pwr_evt_i;
        evt[SRC_ALM] = alm_evt_i;
    end

    irqc_ctrl_reg #(.CTRL_W(CTRL_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (ctrl_wr_i),
        .wdata_i (ctrl_wdata_i),
        .ctrl_o  (ctrl),
        .rdata_o (ctrl_o)
    );

    irqc_flags u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_i       (evt),
        .rd_active_i (flag_rd_i),
        .rd_we_hi_i  (rd_we_hi_i),
        .flags_q_o   (flags_q),
        .flags_d_o   (flags_d)
    );

    irqc_pin_fsm #(.PULSE_TICKS(PULSE_TICKS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_i     (ctrl),
        .evt_i      (evt),
        .flags_d_i  (flags_d),
        .backup_i   (backup_i),
        .asserted_o (asserted)
    );

    irqc_pin_drv u_drv (
        .asserted_i (asserted),
        .act_high_i (ctrl.act_high),
        .backup_i   (backup_i),
        .vcc_ok_i   (vcc_ok_i),
        .pin_o      (irq_pin_o),
        .oe_o       (irq_oe_o)
    );

    assign flags_o = flags_q;

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int unsigned CTRL_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wdt_evt_i,
    input logic              pwr_evt_i,
    input logic              alm_evt_i,
    input logic [CTRL_W-1:0] ctrl_o,
    input logic              flag_rd_i,
    input logic              rd_we_hi_i,
    input logic [2:0]        flags_o,
    input logic              backup_i,
    input logic              vcc_ok_i,
    input logic              irq_pin_o,
    input logic              irq_oe_o
);

    assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_o >> 5) == '0);

    assert_wdt_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_evt_i |=> flags_o[0]);

    assert_alm_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        alm_evt_i |=> flags_o[2]);

    assert_read_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(flag_rd_i) && rd_we_hi_i && !wdt_evt_i && !pwr_evt_i && !alm_evt_i)
        |=> (flags_o == 3'b000));

    assert_level_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_o[4] && !ctrl_o[3] && !backup_i && $stable(ctrl_o) && $stable(backup_i)
         && ((flags_o & ctrl_o[2:0]) != 3'b000)) |-> irq_oe_o);

    assert_hi_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_o[3] && !backup_i && vcc_ok_i) |-> irq_oe_o);

    assert_od_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_o[3] |-> !irq_pin_o);

    assert_backup_od_R11: assert property (@(posedge clk) disable iff (!rst_n)
        backup_i |-> !irq_pin_o);

endmodule

bind irq_combiner irqc_checker #(.CTRL_W(CTRL_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wdt_evt_i  (wdt_evt_i),
    .pwr_evt_i  (pwr_evt_i),
    .alm_evt_i  (alm_evt_i),
    .ctrl_o     (ctrl_o),
    .flag_rd_i  (flag_rd_i),
    .rd_we_hi_i (rd_we_hi_i),
    .flags_o    (flags_o),
    .backup_i   (backup_i),
    .vcc_ok_i   (vcc_ok_i),
    .irq_pin_o  (irq_pin_o),
    .irq_oe_o   (irq_oe_o)
);

// File: tb/irq_combiner_tb_top.sv
`timescale 1ns/1ps
module irq_combiner_tb_top;

    localparam int unsigned PT = 5;
    localparam int NVEC = 9;
    // {ctrl[4:0], evt{alm,pwr,wdt}, backup, vcc_ok, exp_pin, exp_oe}
    localparam logic [11:0] VEC [NVEC] = '{
        12'b00111_001_0_1_0_1,
        12'b00001_010_0_1_0_0,
        12'b01010_010_0_1_1_1,
        12'b01010_001_0_1_0_1,
        12'b01111_100_0_0_0_0,
        12'b00111_001_1_1_0_0,
        12'b00100_100_1_1_0_1,
        12'b01100_100_1_0_0_1,
        12'b00000_111_0_1_0_0
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wdt_evt = 1'b0, pwr_evt = 1'b0, alm_evt = 1'b0;
    logic       ctrl_wr = 1'b0;
    logic [7:0] ctrl_wdata = '0;
    logic [7:0] ctrl_rd;
    logic       flag_rd = 1'b0;
    logic       we_hi = 1'b1;
    logic [2:0] flags;
    logic       backup = 1'b0;
    logic       vcc_ok = 1'b1;
    logic       pin, oe;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_combiner #(.PULSE_TICKS(PT), .CTRL_W(8)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .wdt_evt_i    (wdt_evt),
        .pwr_evt_i    (pwr_evt),
        .alm_evt_i    (alm_evt),
        .ctrl_wr_i    (ctrl_wr),
        .ctrl_wdata_i (ctrl_wdata),
        .ctrl_o       (ctrl_rd),
        .flag_rd_i    (flag_rd),
        .rd_we_hi_i   (we_hi),
        .flags_o      (flags),
        .backup_i     (backup),
        .vcc_ok_i     (vcc_ok),
        .irq_pin_o    (pin),
        .irq_oe_o     (oe)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_ctrl(input logic [7:0] v);
        ctrl_wr = 1'b1;
        ctrl_wdata = v;
        tick();
        ctrl_wr = 1'b0;
    endtask

    task automatic clear_flags();
        flag_rd = 1'b1;
        tick();
        flag_rd = 1'b0;
        we_hi = 1'b1;
        tick();
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    initial begin
        int cnt;
        logic [11:0] v;

        // R1: reset state
        tick(); tick();
        rst_n = 1'b1;
        tick();
        check("R1 ctrl reset", ctrl_rd, 0);
        check("R1 flags reset", flags, 0);
        check("R1 oe reset", oe, 0);
        check("R1 pin reset", pin, 0);
        write_ctrl(8'hFF);
        check("R1 reserved bits read zero", ctrl_rd, 8'h1F);
        write_ctrl(8'h00);

        // Table: level mode, polarity, enables, backup, supply
        for (int i = 0; i < NVEC; i++) begin
            v = VEC[i];
            backup = v[3];
            vcc_ok = v[2];
            write_ctrl({3'b000, v[11:7]});
            {alm_evt, pwr_evt, wdt_evt} = v[6:4];
            tick();
            {alm_evt, pwr_evt, wdt_evt} = 3'b000;
            check($sformatf("R2 vec%0d flags", i), flags, v[6:4]);
            check($sformatf("R5 R6 R9 R10 R11 vec%0d pin", i), pin, v[1]);
            check($sformatf("R5 R6 R9 R10 R11 vec%0d oe", i), oe, v[0]);
            clear_flags();
            backup = 1'b0;
            vcc_ok = 1'b1;
        end

        // R3: clear only after a completed read with write-enable high
        write_ctrl(8'h01);
        wdt_evt = 1'b1; tick(); wdt_evt = 1'b0;
        check("R5 level asserted", oe, 1);
        flag_rd = 1'b1;
        tick(); tick(); tick();
        check("R3 no clear while read held", flags, 1);
        check("R5 level held during read", oe, 1);
        we_hi = 1'b0; flag_rd = 1'b0;
        tick();
        check("R3 no clear with we low", flags, 1);
        we_hi = 1'b1;
        clear_flags();
        check("R3 cleared after read", flags, 0);
        check("R5 level released on clear", oe, 0);

        // R4: event on clearing edge survives
        wdt_evt = 1'b1; tick(); wdt_evt = 1'b0;
        flag_rd = 1'b1; tick();
        flag_rd = 1'b0; alm_evt = 1'b1; tick(); alm_evt = 1'b0;
        check("R4 event beats clear", flags, 3'b100);
        clear_flags();

        // R7: pulse length
        write_ctrl(8'h17);
        wdt_evt = 1'b1; tick(); wdt_evt = 1'b0;
        cnt = 0;
        while (oe && cnt < 50) begin cnt++; tick(); end
        check("R7 pulse length", cnt, PT);
        clear_flags();

        // R8: event during pulse does not extend it
        wdt_evt = 1'b1; tick(); wdt_evt = 1'b0;
        cnt = 0;
        while (oe && cnt < 50) begin
            cnt++;
            if (cnt == 2) pwr_evt = 1'b1;
            tick();
            pwr_evt = 1'b0;
        end
        check("R8 pulse not extended", cnt, PT);
        check("R8 flag recorded", flags, 3'b011);

        // R12: pending flag does not retrigger
        tick(); tick(); tick();
        check("R12 no retrigger", oe, 0);
        check("R12 flags still pending", flags, 3'b011);

        done = 1'b1;
        report();
    end

endmodule